// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It does this by reading two levels of page table from memory. A requester presents the virtual address, the kind of access (read, write or instruction fetch) and the current root of the table. The walker reads a directory entry from the root table. If that entry is valid, it reads a leaf entry from the second-level table the directory entry points to. It then returns either the physical address or a fault code.

Memory is reached over a plain read port that has only one read in flight at a time. The walker raises a one-cycle read strobe with an address. The memory answers with a data-valid pulse some cycles later. The walk ends early, after one read, when the directory entry is not valid.

The root value is taken with each request. Switching address spaces therefore only means presenting a different root with the next request.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_valid`, `req_vaddr`, `req_kind` and `root_base` are ignored while a walk is in progress.
- R2: The first read goes to `root_base + 4*vaddr[31:22]`, using the root value sampled when the request was taken.
- R3: The second read goes to `{dirPPN, 12'h000} + 4*vaddr[21:12]`, where dirPPN is bits 31:12 of the directory entry.
- R4: Each read is a single-cycle `mem_req` pulse. After a pulse, no new pulse is raised until `mem_rvalid` has returned the data.
- R5: Every table entry has bit 0 = valid, bits 2:1 = rights (00 none, 01 read-only, 10 read/write, 11 execute) and bits 31:12 = page number. A successful response reports the leaf rights on `rsp_rights`.
- R6: A directory entry with bit 0 clear ends the walk with no second read, with fault code 1.
- R7: A valid directory entry whose leaf has bit 0 clear gives fault code 2.
- R8: `req_kind` is encoded 0 read, 1 write, 2 fetch, 3 reserved. A read needs rights 01 or 10, a write needs 10, and a fetch needs 11. Rights 00, kind 3, or any other mismatch gives fault code 3.
- R9: On success the fault code is 0 and `rsp_paddr` is the leaf page number joined with the unchanged `vaddr[11:0]`.
- R10: `rsp_valid` is high for exactly one cycle per request. On any fault, `rsp_paddr` and `rsp_rights` are zero.
- R11: During and directly after reset the walker is idle: `req_ready` is 1, and `mem_req` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_base | input | 32 | Physical address of the first-level table, sampled with each request |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 reserved |
| mem_req | output | 1 | One-cycle read strobe to memory |
| mem_addr | output | 32 | Byte address of the table entry being read |
| mem_rvalid | input | 1 | Read data valid from memory |
| mem_rdata | input | 32 | Table entry returned by memory |
| rsp_valid | output | 1 | Response valid, one cycle |
| rsp_fault | output | 2 | 0 none, 1 directory invalid, 2 leaf invalid, 3 rights violation |
| rsp_rights | output | 2 | Leaf rights on success, zero on fault |
| rsp_paddr | output | 32 | Physical address on success, zero on fault |

## Verification
The bench builds the walker with its default widths: 10-bit indexes at both levels and a 12-bit offset. This lets it use directory and leaf indexes at 0 and at the top value 1023, a page offset of 0xFFF, and a page number of all ones. It varies the memory latency between one and three cycles, so each wait state both holds and releases. It also changes the root and the request inputs in the middle of a walk, to show that the root is sampled only when a request is taken.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE
  } walk_st_e;

  localparam logic [1:0] FLT_NONE         = 2'd0;
  localparam logic [1:0] FLT_DIR_INVALID  = 2'd1;
  localparam logic [1:0] FLT_LEAF_INVALID = 2'd2;
  localparam logic [1:0] FLT_PROT         = 2'd3;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam logic [1:0] RT_NONE = 2'd0;
  localparam logic [1:0] RT_RO   = 2'd1;
  localparam logic [1:0] RT_RW   = 2'd2;
  localparam logic [1:0] RT_EXEC = 2'd3;

  // Rights check for one access kind (R8)
  function automatic logic access_ok(input logic [1:0] rights, input logic [1:0] kind);
    logic ok;
    case (kind)
      ACC_READ:  ok = (rights == RT_RO) || (rights == RT_RW);
      ACC_WRITE: ok = (rights == RT_RW);
      ACC_FETCH: ok = (rights == RT_EXEC);
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12,
  localparam int AW   = 2 * IDX_W + OFF_W
) (
  input  logic [AW-1:0]      root_base,
  input  logic [AW-1:0]      leaf_base,
  input  logic [2*IDX_W-1:0] vpn,
  input  logic               sel_leaf,
  output logic [AW-1:0]      ent_addr
);

  // Table slot address: base plus index scaled by the 4-byte entry size
  function automatic logic [AW-1:0] slot_addr(input logic [AW-1:0] base,
                                               input logic [IDX_W-1:0] idx);
    return base + (AW'(idx) << 2);
  endfunction

  logic [IDX_W-1:0] dir_idx, leaf_idx;
  assign dir_idx  = vpn[2*IDX_W-1:IDX_W];
  assign leaf_idx = vpn[IDX_W-1:0];

  assign ent_addr = sel_leaf ? slot_addr(leaf_base, leaf_idx)
                             : slot_addr(root_base, dir_idx);

  always_comb begin
    a_r2_aligned: assert (sel_leaf || root_base[1:0] != 2'b00 || ent_addr[1:0] == 2'b00);
  end

endmodule

// File: rtl/ptw_leaf_check.sv
module ptw_leaf_check
  import ptw_pkg::*;
#(
  parameter int AW    = 32,
  parameter int OFF_W = 12
) (
  input  logic [AW-1:0]    leaf_ent,
  input  logic [1:0]       kind,
  input  logic [OFF_W-1:0] page_off,
  output logic [1:0]       fault,
  output logic [1:0]       rights,
  output logic [AW-1:0]    paddr
);

  logic ent_unused;
  assign ent_unused = ^leaf_ent[OFF_W-1:3];

  logic       ent_valid;
  logic [1:0] ent_rights;
  assign ent_valid  = leaf_ent[0];
  assign ent_rights = leaf_ent[2:1];

  always_comb begin
    fault  = FLT_NONE;
    rights = ent_rights;
    paddr  = {leaf_ent[AW-1:OFF_W], page_off};
    if (!ent_valid) begin
      fault  = FLT_LEAF_INVALID;
      rights = '0;
      paddr  = '0;
    end else if (!access_ok(ent_rights, kind)) begin
      fault  = FLT_PROT;
      rights = '0;
      paddr  = '0;
    end
  end

  always_comb begin
    a_r10_fault_clears: assert (fault == FLT_NONE || (paddr == '0 && rights == '0));
  end

endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter int AW    = 32,
  parameter int OFF_W = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_vaddr,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] req_base,
  output logic          req_ready,
  output logic [AW-1:0] lat_vaddr,
  output logic [1:0]    lat_kind,
  output logic [AW-1:0] lat_base,
  output logic [AW-1:0] leaf_base,
  output logic          sel_leaf,
  output logic          mem_req,
  input  logic          mem_rvalid,
  input  logic [AW-1:0] mem_rdata,
  input  logic [1:0]    leaf_fault,
  input  logic [1:0]    leaf_rights,
  input  logic [AW-1:0] leaf_paddr,
  output logic          rsp_valid,
  output logic [1:0]    rsp_fault,
  output logic [1:0]    rsp_rights,
  output logic [AW-1:0] rsp_paddr
);

  walk_st_e state;

  logic rdata_unused;
  assign rdata_unused = ^mem_rdata[OFF_W-1:1];

  // Named internal events
  logic ev_accept, ev_dir_fault, ev_dir_ok, ev_leaf_done;
  assign ev_accept    = (state == ST_IDLE) && req_valid;
  assign ev_dir_fault = (state == ST_L1_WAIT) && mem_rvalid && !mem_rdata[0];
  assign ev_dir_ok    = (state == ST_L1_WAIT) && mem_rvalid && mem_rdata[0];
  assign ev_leaf_done = (state == ST_L2_WAIT) && mem_rvalid;

  assign req_ready = (state == ST_IDLE);
  assign mem_req   = (state == ST_L1_REQ) || (state == ST_L2_REQ);
  assign sel_leaf  = (state == ST_L2_REQ);
  assign rsp_valid = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      lat_vaddr  <= '0;
      lat_kind   <= '0;
      lat_base   <= '0;
      leaf_base  <= '0;
      rsp_fault  <= FLT_NONE;
      rsp_rights <= '0;
      rsp_paddr  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (ev_accept) begin
          lat_vaddr <= req_vaddr;
          lat_kind  <= req_kind;
          lat_base  <= req_base;
          state     <= ST_L1_REQ;
        end
        ST_L1_REQ: state <= ST_L1_WAIT;
        ST_L1_WAIT: begin
          if (ev_dir_ok) begin
            leaf_base <= {mem_rdata[AW-1:OFF_W], {OFF_W{1'b0}}};
            state     <= ST_L2_REQ;
          end else if (ev_dir_fault) begin
            rsp_fault  <= FLT_DIR_INVALID;
            rsp_rights <= '0;
            rsp_paddr  <= '0;
            state      <= ST_DONE;
          end
        end
        ST_L2_REQ: state <= ST_L2_WAIT;
        ST_L2_WAIT: if (ev_leaf_done) begin
          rsp_fault  <= leaf_fault;
          rsp_rights <= leaf_rights;
          rsp_paddr  <= leaf_paddr;
          state      <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r1_accept_issues: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (mem_req && !req_ready));
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  a_r6_dir_fault_early: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dir_fault |=> (rsp_valid && rsp_fault == FLT_DIR_INVALID && !mem_req));
  a_r10_rsp_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12,
  localparam int AW   = 2 * IDX_W + OFF_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] root_base,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_vaddr,
  input  logic [1:0]    req_kind,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [AW-1:0] mem_rdata,
  output logic          rsp_valid,
  output logic [1:0]    rsp_fault,
  output logic [1:0]    rsp_rights,
  output logic [AW-1:0] rsp_paddr
);

  logic [AW-1:0] lat_vaddr, lat_base, leaf_base, leaf_paddr;
  logic [1:0]    lat_kind, leaf_fault, leaf_rights;
  logic          sel_leaf;

  ptw_ctrl #(.AW(AW), .OFF_W(OFF_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_kind(req_kind),
    .req_base(root_base), .req_ready(req_ready),
    .lat_vaddr(lat_vaddr), .lat_kind(lat_kind), .lat_base(lat_base),
    .leaf_base(leaf_base), .sel_leaf(sel_leaf), .mem_req(mem_req),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .leaf_fault(leaf_fault), .leaf_rights(leaf_rights), .leaf_paddr(leaf_paddr),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_rights(rsp_rights), .rsp_paddr(rsp_paddr)
  );

  ptw_addr_gen #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_addr (
    .root_base(lat_base), .leaf_base(leaf_base),
    .vpn(lat_vaddr[AW-1:OFF_W]), .sel_leaf(sel_leaf), .ent_addr(mem_addr)
  );

  ptw_leaf_check #(.AW(AW), .OFF_W(OFF_W)) u_leaf (
    .leaf_ent(mem_rdata), .kind(lat_kind), .page_off(lat_vaddr[OFF_W-1:0]),
    .fault(leaf_fault), .rights(leaf_rights), .paddr(leaf_paddr)
  );

  a_r9_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == FLT_NONE) |-> rsp_paddr[OFF_W-1:0] == lat_vaddr[OFF_W-1:0]);
  a_r10_fault_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_paddr == '0 && rsp_rights == '0));
  a_r3_leaf_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    sel_leaf |-> leaf_base[OFF_W-1:0] == '0);

endmodule

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] root_base = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [31:0] req_vaddr = 0;
  logic [1:0]  req_kind = 0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 0;
  logic [31:0] mem_rdata = 0;
  logic        rsp_valid;
  logic [1:0]  rsp_fault, rsp_rights;
  logic [31:0] rsp_paddr;

  always #4 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n), .root_base(root_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_rights(rsp_rights), .rsp_paddr(rsp_paddr)
  );

  int checks = 0;
  int failures = 0;
  logic [31:0] mem [logic [31:0]];

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] mkva(input int d, input int l, input int off);
    return (32'(d) << 22) | (32'(l) << 12) | 32'(off);
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: walk phase counter plus expected result
  int          ph = 0;
  logic [31:0] m_va, m_base, m_l2;
  logic [1:0]  m_kind;
  int          e_fault;
  logic [1:0]  e_rights;
  logic [31:0] e_paddr;

  always @(posedge clk) begin
    if (!rst_n) ph = 0;
    else case (ph)
      0: if (req_valid) begin m_va = req_vaddr; m_kind = req_kind; m_base = root_base; ph = 1; end
      1: ph = 2;
      2: if (mem_rvalid) begin
           if (mem_rdata[0] == 1'b0) begin e_fault = 1; e_rights = 0; e_paddr = 0; ph = 5; end
           else begin m_l2 = mem_rdata & 32'hFFFF_F000; ph = 3; end
         end
      3: ph = 4;
      4: if (mem_rvalid) begin
           int r;
           bit ok;
           r = int'(mem_rdata[2:1]);
           ok = (m_kind == 0 && (r == 1 || r == 2)) || (m_kind == 1 && r == 2) ||
                (m_kind == 2 && r == 3);
           if (mem_rdata[0] == 1'b0) begin e_fault = 2; e_rights = 0; e_paddr = 0; end
           else if (!ok) begin e_fault = 3; e_rights = 0; e_paddr = 0; end
           else begin e_fault = 0; e_rights = mem_rdata[2:1];
                      e_paddr = {mem_rdata[31:12], m_va[11:0]}; end
           ph = 5;
         end
      default: ph = 0;
    endcase
  end

  // Memory responder and per-cycle comparison
  int          lat_cfg = 1;
  int          pend_cnt = 0;
  logic [31:0] pend_addr = 0;

  always @(negedge clk) begin
    mem_rvalid = 0;
    if (pend_cnt > 0) begin
      pend_cnt--;
      if (pend_cnt == 0) begin mem_rvalid = 1; mem_rdata = rd(pend_addr); end
    end
    if (mem_req) begin pend_addr = mem_addr; pend_cnt = lat_cfg; end
    if (rst_n) begin
      chk(32'(req_ready), 32'(ph == 0), "R1 req_ready");
      chk(32'(mem_req), 32'(ph == 1 || ph == 3), "R4 mem_req");
      if (ph == 1) chk(mem_addr, m_base + ((m_va >> 22) << 2), "R2 dir addr");
      if (ph == 3) chk(mem_addr, m_l2 + (((m_va >> 12) & 32'h3FF) << 2), "R3 leaf addr");
      chk(32'(rsp_valid), 32'(ph == 5), "R10 rsp_valid");
      if (ph == 5 && rsp_valid) begin
        case (e_fault)
          0: chk(32'(rsp_fault), 0, "R9 fault");
          1: chk(32'(rsp_fault), 1, "R6 fault");
          2: chk(32'(rsp_fault), 2, "R7 fault");
          default: chk(32'(rsp_fault), 3, "R8 fault");
        endcase
        chk(rsp_paddr, e_paddr, e_fault == 0 ? "R9 paddr" : "R10 paddr");
        chk(32'(rsp_rights), 32'(e_rights), "R5 rights");
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic [1:0] kind,
                      input logic [31:0] base, input int lat, input bit disturb);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    lat_cfg = lat;
    req_vaddr = va; req_kind = kind; root_base = base; req_valid = 1;
    @(negedge clk);
    if (disturb) begin
      // R1: inputs change mid-walk and must be ignored
      req_vaddr = ~va; req_kind = 2'd2; root_base = 32'h0007_0000;
    end else req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    req_valid = 0;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  localparam logic [31:0] ROOT_A = 32'h0001_0000;
  localparam logic [31:0] ROOT_B = 32'h0007_0000;

  initial begin
    mem[ROOT_A + 4]          = 32'h0005_0001;
    mem[ROOT_A + 12]         = 32'h0006_0000;   // valid bit clear, nonzero body
    mem[ROOT_A + 32'hFFC]    = 32'h0006_0001;
    mem[32'h0005_0000]       = 32'hABCD_E003;   // read-only
    mem[32'h0005_0004]       = 32'h1234_5005;   // read/write
    mem[32'h0005_0008]       = 32'h7777_7007;   // execute
    mem[32'h0005_000C]       = 32'h1111_1001;   // no rights
    mem[32'h0005_0010]       = 32'h2222_2004;   // not resident
    mem[32'h0005_0FFC]       = 32'hFFFF_F005;
    mem[32'h0006_0000]       = 32'h0000_1005;
    mem[ROOT_B + 4]          = 32'h0008_0001;
    mem[32'h0008_0000]       = 32'h0BEE_F003;

    repeat (3) @(negedge clk);
    chk(32'(req_ready), 1, "R11 ready in reset");
    chk(32'(mem_req), 0, "R11 no read in reset");
    chk(32'(rsp_valid), 0, "R11 no response in reset");
    rst_n = 1;
    @(negedge clk);
    chk(32'(req_ready), 1, "R11 ready after reset");

    walk(mkva(1, 0, 12'h123), 2'd0, ROOT_A, 1, 0);  // R9 read on read-only
    walk(mkva(1, 0, 12'h010), 2'd1, ROOT_A, 2, 0);  // R8 write on read-only
    walk(mkva(1, 1, 12'h456), 2'd1, ROOT_A, 3, 0);  // R9 write on read/write
    walk(mkva(1, 1, 12'h000), 2'd0, ROOT_A, 1, 0);  // R9 read on read/write
    walk(mkva(1, 1, 12'h004), 2'd2, ROOT_A, 1, 0);  // R8 fetch on read/write
    walk(mkva(1, 2, 12'h888), 2'd2, ROOT_A, 2, 0);  // R5 fetch on execute
    walk(mkva(1, 2, 12'h888), 2'd0, ROOT_A, 1, 0);  // R8 read on execute
    walk(mkva(1, 3, 12'h001), 2'd0, ROOT_A, 1, 0);  // R8 rights none
    walk(mkva(1, 1, 12'h002), 2'd3, ROOT_A, 1, 0);  // R8 reserved kind
    walk(mkva(1, 4, 12'h003), 2'd0, ROOT_A, 3, 0);  // R7 leaf invalid
    walk(mkva(2, 0, 12'h000), 2'd0, ROOT_A, 1, 0);  // R6 empty directory slot
    walk(mkva(3, 0, 12'h000), 2'd0, ROOT_A, 2, 0);  // R6 valid bit clear
    walk(mkva(1023, 0, 12'hFFF), 2'd1, ROOT_A, 1, 0); // R2 top directory index
    walk(mkva(1, 1023, 12'hABC), 2'd0, ROOT_A, 2, 0); // R3 top leaf index
    walk(mkva(1, 0, 12'h777), 2'd0, ROOT_B, 1, 0);  // R2 other root
    walk(mkva(1, 1, 12'h5A5), 2'd1, ROOT_A, 3, 1);  // R1 inputs disturbed
    walk(mkva(2, 0, 12'h000), 2'd0, ROOT_A, 2, 1);  // R1 disturbed, early fault
    repeat (4) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule